// File: doc/BRIEF.md
# Page-Walk Leaf Isolation Guard

This block sits on the response path between a hardware page-table walker and the TLB. Each leaf entry the walker returns is held against a set of isolation rules before it may be installed. A mapping that lands in protected monitor memory is refused. So is a mapping whose physical page falls in a DRAM region the current context does not own, and a leaf entry that was fetched from outside the context's permitted page-table area. Only an entry that passes every rule raises the valid bit toward the TLB. A refused entry raises a one-cycle access fault instead, so the core can trap.

Two banks of context registers exist: one for the OS and one for the enclave. The walk's virtual address picks the bank. The address is masked and compared against an enclave base pair. The chosen bank supplies the translation root that the walker starts from, as well as the region bitmap and page-table window used by the checks.

Configuration is written through a port that accepts writes only in machine mode. A write lands in a staging copy and moves to the active copy only while no walk is outstanding. A walk therefore never sees a half-changed configuration. The checks are combinational and add no cycle to the response path.

Top module: `ptw_leaf_guard`

## Requirements
- R1: `tlb_valid_o` is high in exactly the cycles where `resp_valid_i` is high and every rule of R2, R3 and R4 passes, in the same cycle and with no added latency.
- R2: With leaf physical address PA = {`resp_ppn_i`, 12'b0}, an entry is refused when (PA & monitor mask) == monitor base.
- R3: PA bits [12 +: REGION_W] (bits 14..12 by default) index the selected bank's region bitmap, which is 2**REGION_W bits wide. The entry is refused when the indexed bit is 0.
- R4: The entry is refused unless (`resp_pte_addr_i` & bank page-table mask) == bank page-table base.
- R5: A virtual address selects the enclave bank when (`walk_va_i` & enclave mask) == enclave base, and the OS bank otherwise. `enclave_sel_o` shows the choice, and `walk_root_o` carries that bank's root.
- R6: `access_fault_o` is high exactly when `resp_valid_i` is high and the entry is refused. It is never high together with `tlb_valid_o`.
- R7: Configuration writes take `cfg_sel_i` codes as follows: 0 OS root, 1 OS bitmap, 2 OS page-table base, 3 OS page-table mask, 4 to 7 the same four fields for the enclave bank, 8 enclave base, 9 enclave mask, 10 monitor base, 11 monitor mask. A write with `cfg_mmode_i` low, or with a code of 12 or above, has no effect.
- R8: A walk is outstanding from the cycle after `walk_start_i` until the end of the cycle that carries `resp_valid_i`. A write becomes active in the second cycle after it, or later if it must wait: the active configuration never changes while a walk is outstanding or in the cycle of `walk_start_i`.
- R9: After reset, both roots and bitmaps, all masks and all bases are zero, except the enclave base, which is all ones. As a result every entry is refused and the enclave bank is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mmode_i | input | 1 | Writer is in machine mode |
| cfg_sel_i | input | 4 | Register code (R7) |
| cfg_wdata_i | input | 64 | Write data |
| walk_start_i | input | 1 | Walker begins a walk |
| walk_va_i | input | VA_W (39) | Virtual address under walk, held for the whole walk |
| walk_root_o | output | PA_W (40) | Translation root of the selected bank |
| enclave_sel_o | output | 1 | Enclave bank selected |
| resp_valid_i | input | 1 | Walker leaf response valid |
| resp_pte_addr_i | input | PA_W (40) | Physical address the leaf entry was read from |
| resp_ppn_i | input | PA_W-12 (28) | Physical page number in the leaf entry |
| tlb_valid_o | output | 1 | Gated valid toward the TLB |
| access_fault_o | output | 1 | Refused-entry pulse |

## Verification
All sixteen combinations of the four inputs are driven on purpose: monitor hit or miss, region bit set or clear, page-table address inside or outside its window, and OS or enclave address. Each one shows that a single rule alone can refuse an entry, and that the bank choice changes which bitmap and window apply. Random walks then mix addresses near the monitor range, near both windows and near the enclave base. Their results are compared against a bench model. Timed writes show three things: a write issued during a walk is not seen by that walk's response, a write made outside machine mode is dropped, and the reset configuration refuses everything.

// File: rtl/ptw_guard_pkg.sv
package ptw_guard_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned NREG   = 12;

  typedef enum logic [3:0] {
    SEL_OS_ROOT   = 4'd0,
    SEL_OS_RMAP   = 4'd1,
    SEL_OS_PTBASE = 4'd2,
    SEL_OS_PTMASK = 4'd3,
    SEL_EN_ROOT   = 4'd4,
    SEL_EN_RMAP   = 4'd5,
    SEL_EN_PTBASE = 4'd6,
    SEL_EN_PTMASK = 4'd7,
    SEL_EV_BASE   = 4'd8,
    SEL_EV_MASK   = 4'd9,
    SEL_MON_BASE  = 4'd10,
    SEL_MON_MASK  = 4'd11
  } cfg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0] root;
    logic [DATA_W-1:0] rmap;
    logic [DATA_W-1:0] ptbase;
    logic [DATA_W-1:0] ptmask;
  } bank_t;
endpackage

// File: rtl/ptw_guard_cfg.sv
module ptw_guard_cfg
  import ptw_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_mmode_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              walk_start_i,
  input  logic              resp_valid_i,
  output bank_t [1:0]       banks_o,
  output logic [DATA_W-1:0] ev_base_o,
  output logic [DATA_W-1:0] ev_mask_o,
  output logic [DATA_W-1:0] mon_base_o,
  output logic [DATA_W-1:0] mon_mask_o
);
  logic [NREG-1:0][DATA_W-1:0] staged_q, active_q;
  logic busy_q, commit, wr_ok;

  assign wr_ok  = cfg_we_i && cfg_mmode_i && (32'(cfg_sel_i) < NREG);
  assign commit = !busy_q && !walk_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else if (walk_start_i) busy_q <= 1'b1;
    else if (resp_valid_i) busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) begin
        staged_q[i] <= (i == int'(SEL_EV_BASE)) ? '1 : '0;
        active_q[i] <= (i == int'(SEL_EV_BASE)) ? '1 : '0;
      end
    end else begin
      if (wr_ok) staged_q[cfg_sel_i] <= cfg_wdata_i;
      if (commit) active_q <= staged_q;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign banks_o[b].root   = active_q[4*b + 0];
    assign banks_o[b].rmap   = active_q[4*b + 1];
    assign banks_o[b].ptbase = active_q[4*b + 2];
    assign banks_o[b].ptmask = active_q[4*b + 3];
  end

  assign ev_base_o  = active_q[SEL_EV_BASE];
  assign ev_mask_o  = active_q[SEL_EV_MASK];
  assign mon_base_o = active_q[SEL_MON_BASE];
  assign mon_mask_o = active_q[SEL_MON_MASK];

  AST_HOLD_DURING_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(active_q)) else $error("active cfg moved mid-walk"); // R8
  AST_START_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_start_i |=> $stable(active_q)) else $error("cfg moved at walk start"); // R8
  AST_USER_WRITE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_mmode_i) |=> $stable(staged_q)) else $error("non-machine write landed"); // R7
endmodule

// File: rtl/ptw_guard_bank_sel.sv
module ptw_guard_bank_sel
  import ptw_guard_pkg::*;
#(
  parameter int unsigned VA_W = 39,
  parameter int unsigned PA_W = 40
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [DATA_W-1:0] ev_base_i,
  input  logic [DATA_W-1:0] ev_mask_i,
  input  bank_t [1:0]       banks_i,
  output logic              enclave_o,
  output bank_t             bank_o,
  output logic [PA_W-1:0]   root_o
);
  assign enclave_o = ((va_i & ev_mask_i[VA_W-1:0]) == ev_base_i[VA_W-1:0]);
  assign bank_o    = banks_i[enclave_o];
  assign root_o    = bank_o.root[PA_W-1:0];
endmodule

// File: rtl/ptw_guard_leaf_chk.sv
module ptw_guard_leaf_chk
  import ptw_guard_pkg::*;
#(
  parameter int unsigned PA_W     = 40,
  parameter int unsigned PG_OFF   = 12,
  parameter int unsigned REGION_W = 3
) (
  input  logic [PA_W-PG_OFF-1:0] ppn_i,
  input  logic [PA_W-1:0]        pte_addr_i,
  input  bank_t                  bank_i,
  input  logic [DATA_W-1:0]      mon_base_i,
  input  logic [DATA_W-1:0]      mon_mask_i,
  output logic                   mon_hit_o,
  output logic                   region_ok_o,
  output logic                   pt_ok_o
);
  localparam int unsigned NRGN = 2 ** REGION_W;

  logic [PA_W-1:0]     pa;
  logic [REGION_W-1:0] rgn_idx;
  logic [NRGN-1:0]     rgn_onehot;

  assign pa      = {ppn_i, {PG_OFF{1'b0}}};
  assign rgn_idx = pa[PG_OFF +: REGION_W];

  for (genvar i = 0; i < NRGN; i++) begin : g_dec
    assign rgn_onehot[i] = (rgn_idx == REGION_W'(i));
  end

  assign mon_hit_o   = ((pa & mon_mask_i[PA_W-1:0]) == mon_base_i[PA_W-1:0]);
  assign region_ok_o = |(rgn_onehot & bank_i.rmap[NRGN-1:0]);
  assign pt_ok_o     = ((pte_addr_i & bank_i.ptmask[PA_W-1:0]) == bank_i.ptbase[PA_W-1:0]);

  initial AST_RGN_FITS: assert (NRGN <= DATA_W && PG_OFF + REGION_W <= PA_W)
    else $error("region width too large"); // R3

  always_comb begin
    AST_ONEHOT_DEC: assert ($onehot(rgn_onehot) || $isunknown(rgn_idx))
      else $error("region decode not one-hot"); // R3
  end
endmodule

// File: rtl/ptw_leaf_guard.sv
module ptw_leaf_guard
  import ptw_guard_pkg::*;
#(
  parameter int unsigned VA_W     = 39,
  parameter int unsigned PA_W     = 40,
  parameter int unsigned PG_OFF   = 12,
  parameter int unsigned REGION_W = 3,
  localparam int unsigned PPN_W   = PA_W - PG_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_mmode_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              walk_start_i,
  input  logic [VA_W-1:0]   walk_va_i,
  output logic [PA_W-1:0]   walk_root_o,
  output logic              enclave_sel_o,
  input  logic              resp_valid_i,
  input  logic [PA_W-1:0]   resp_pte_addr_i,
  input  logic [PPN_W-1:0]  resp_ppn_i,
  output logic              tlb_valid_o,
  output logic              access_fault_o
);
  bank_t [1:0]       banks;
  bank_t             bank_cur;
  logic [DATA_W-1:0] ev_base, ev_mask, mon_base, mon_mask;
  logic              mon_hit, region_ok, pt_ok, entry_ok;

  ptw_guard_cfg u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_mmode_i, .cfg_sel_i, .cfg_wdata_i,
    .walk_start_i, .resp_valid_i,
    .banks_o(banks), .ev_base_o(ev_base), .ev_mask_o(ev_mask),
    .mon_base_o(mon_base), .mon_mask_o(mon_mask)
  );

  ptw_guard_bank_sel #(.VA_W(VA_W), .PA_W(PA_W)) u_sel (
    .va_i(walk_va_i), .ev_base_i(ev_base), .ev_mask_i(ev_mask), .banks_i(banks),
    .enclave_o(enclave_sel_o), .bank_o(bank_cur), .root_o(walk_root_o)
  );

  ptw_guard_leaf_chk #(.PA_W(PA_W), .PG_OFF(PG_OFF), .REGION_W(REGION_W)) u_chk (
    .ppn_i(resp_ppn_i), .pte_addr_i(resp_pte_addr_i), .bank_i(bank_cur),
    .mon_base_i(mon_base), .mon_mask_i(mon_mask),
    .mon_hit_o(mon_hit), .region_ok_o(region_ok), .pt_ok_o(pt_ok)
  );

  assign entry_ok       = !mon_hit && region_ok && pt_ok;
  assign tlb_valid_o    = resp_valid_i && entry_ok;
  assign access_fault_o = resp_valid_i && !entry_ok;

  AST_TLB_NEEDS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_valid_o |-> resp_valid_i) else $error("valid without response"); // R1
  AST_NO_MON_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_valid_o |-> (({resp_ppn_i, {PG_OFF{1'b0}}} & mon_mask[PA_W-1:0]) != mon_base[PA_W-1:0]))
    else $error("monitor page installed"); // R2
  AST_REGION_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_valid_o |-> bank_cur.rmap[resp_ppn_i[REGION_W-1:0]])
    else $error("unowned region installed"); // R3
  AST_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i |-> $onehot({tlb_valid_o, access_fault_o}))
    else $error("fault and valid not exclusive"); // R6
  AST_FAULT_NEEDS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_fault_o |-> resp_valid_i) else $error("fault without response"); // R6
endmodule

// File: tb/ptw_leaf_guard_tb.sv
module ptw_leaf_guard_tb;
  localparam int VA_W = 39, PA_W = 40, PPN_W = 28;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, cfg_mmode = 0;
  logic [3:0] cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic walk_start = 0, resp_valid = 0;
  logic [VA_W-1:0] walk_va = '0;
  logic [PA_W-1:0] walk_root, resp_pte_addr = '0;
  logic [PPN_W-1:0] resp_ppn = '0;
  logic enclave_sel, tlb_valid, access_fault;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m [12];

  always #2.5 clk = ~clk;

  ptw_leaf_guard u_dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_mmode_i(cfg_mmode), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .walk_start_i(walk_start), .walk_va_i(walk_va),
    .walk_root_o(walk_root), .enclave_sel_o(enclave_sel), .resp_valid_i(resp_valid),
    .resp_pte_addr_i(resp_pte_addr), .resp_ppn_i(resp_ppn),
    .tlb_valid_o(tlb_valid), .access_fault_o(access_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_enc(input logic [VA_W-1:0] va);
    return (va & m[9][VA_W-1:0]) == m[8][VA_W-1:0];
  endfunction

  function automatic bit exp_ok(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pte,
                                input logic [PPN_W-1:0] ppn);
    int b = is_enc(va) ? 4 : 0;
    logic [PA_W-1:0] pa = {ppn, 12'h000};
    bit mon = (pa & m[11][PA_W-1:0]) == m[10][PA_W-1:0];
    bit rok = m[b+1][pa[14:12]];
    bit pok = (pte & m[b+3][PA_W-1:0]) == m[b+2][PA_W-1:0];
    return !mon && rok && pok;
  endfunction

  task automatic cfg_write(input int sel, input logic [63:0] d, input bit mm);
    @(negedge clk);
    cfg_we = 1; cfg_mmode = mm; cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_mmode = 0;
    @(negedge clk);
    if (mm && sel < 12) m[sel] = d;
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pte,
                      input logic [PPN_W-1:0] ppn, input string req);
    bit e;
    @(negedge clk);
    walk_start = 1; walk_va = va;
    #1;
    e = is_enc(va);
    chk(enclave_sel == e, "R5 bank select", 64'(enclave_sel), 64'(e));
    chk(walk_root == m[e ? 4 : 0][PA_W-1:0], "R5 root", 64'(walk_root), m[e ? 4 : 0]);
    @(negedge clk);
    walk_start = 0; resp_valid = 1; resp_pte_addr = pte; resp_ppn = ppn;
    #1;
    e = exp_ok(va, pte, ppn);
    chk(tlb_valid == e, {req, " R1 tlb valid"}, 64'(tlb_valid), 64'(e));
    chk(access_fault == !e, {req, " R6 fault"}, 64'(access_fault), 64'(!e));
    @(negedge clk);
    resp_valid = 0;
  endtask

  localparam logic [PA_W-1:0] MON_BASE = 40'h00_8000_0000;
  localparam logic [PA_W-1:0] MON_MASK = 40'hFF_FFE0_0000;
  localparam logic [PA_W-1:0] PT_MASK  = 40'hFF_F000_0000;
  localparam logic [PA_W-1:0] OS_PT    = 40'h01_0000_0000;
  localparam logic [PA_W-1:0] EN_PT    = 40'h02_0000_0000;
  localparam logic [VA_W-1:0] EV_BASE  = 39'h40_0000_0000;
  localparam logic [VA_W-1:0] EV_MASK  = 39'h7F_C000_0000;

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd2024;
    void'($urandom(seed));
    for (int i = 0; i < 12; i++) m[i] = (i == 8) ? '1 : '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R9: reset config refuses everything, no enclave selection
    walk(39'h40_0000_0000, OS_PT, 28'h0_1003, "R9 reset");
    walk(39'h00_1234_5000, 40'h0, 28'h0_0000, "R9 reset zero");

    cfg_write(10, 64'(MON_BASE), 1);
    cfg_write(11, 64'(MON_MASK), 1);
    cfg_write(0, 64'h00_0A00_0000, 1);
    cfg_write(1, 64'hA5, 1);
    cfg_write(2, 64'(OS_PT), 1);
    cfg_write(3, 64'(PT_MASK), 1);
    cfg_write(4, 64'h00_0B00_0000, 1);
    cfg_write(5, 64'h5A, 1);
    cfg_write(6, 64'(EN_PT), 1);
    cfg_write(7, 64'(PT_MASK), 1);
    cfg_write(8, 64'(EV_BASE), 1);
    cfg_write(9, 64'(EV_MASK), 1);

    // directed: every combination of monitor / region / pt window / bank (R2 R3 R4 R5)
    for (int c = 0; c < 16; c++) begin
      bit mon = c[0], rin = c[1], pin = c[2], enc = c[3];
      logic [VA_W-1:0] va = enc ? (EV_BASE | 39'h123_4000) : 39'h00_0012_3000;
      logic [7:0] rm = enc ? 8'h5A : 8'hA5;
      int idx = 0;
      logic [PPN_W-1:0] ppn;
      logic [PA_W-1:0] pte;
      for (int k = 0; k < 8; k++) if (rm[k] == rin) idx = k;
      ppn = mon ? (PPN_W'(MON_BASE >> 12) | PPN_W'(idx)) : (28'h1_0000 | PPN_W'(idx));
      pte = pin ? ((enc ? EN_PT : OS_PT) | 40'h0040) : 40'h03_0000_0040;
      walk(va, pte, ppn, mon ? "R2 directed" : (!rin ? "R3 directed" : "R4 directed"));
    end

    // R7: non-machine write and out-of-range code are dropped
    cfg_write(1, 64'h00, 0);
    walk(39'h00_0000_1000, OS_PT, 28'h1_0000, "R7 user write ignored");
    cfg_write(12, 64'h0, 1);
    cfg_write(15, 64'h0, 1);
    walk(39'h00_0000_1000, OS_PT, 28'h1_0000, "R7 bad code ignored");
    walk(EV_BASE, EN_PT, 28'h1_0001, "R7 bad code ignored enc");

    // R8: write issued mid-walk is not seen by that response
    @(negedge clk);
    walk_start = 1; walk_va = 39'h00_0000_2000;
    @(negedge clk);
    walk_start = 0; cfg_we = 1; cfg_mmode = 1; cfg_sel = 4'd1; cfg_wdata = 64'h00;
    @(negedge clk);
    cfg_we = 0; cfg_mmode = 0;
    resp_valid = 1; resp_pte_addr = OS_PT; resp_ppn = 28'h1_0000;
    #1;
    chk(tlb_valid == 1'b1, "R8 mid-walk write deferred", 64'(tlb_valid), 64'd1);
    @(negedge clk);
    resp_valid = 0;
    @(negedge clk);
    m[1] = 64'h00;
    walk(39'h00_0000_2000, OS_PT, 28'h1_0000, "R8 write active after walk");
    cfg_write(1, 64'hA5, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [VA_W-1:0] va;
      logic [PA_W-1:0] pte;
      logic [PPN_W-1:0] ppn;
      int r = $urandom_range(0, 3);
      va = (r < 2) ? (EV_BASE | VA_W'($urandom_range(0, 32'h3FFF_FFFF))) : VA_W'({$urandom(), $urandom()});
      r = $urandom_range(0, 3);
      pte = (r == 0) ? (OS_PT | PA_W'($urandom() & 32'h0FFF_FFF8)) :
            (r == 1) ? (EN_PT | PA_W'($urandom() & 32'h0FFF_FFF8)) : PA_W'({$urandom(), $urandom()});
      r = $urandom_range(0, 2);
      ppn = (r == 0) ? (PPN_W'(MON_BASE >> 12) | PPN_W'($urandom_range(0, 511))) : PPN_W'($urandom());
      if (i % 97 == 5) cfg_write(1 + 4 * (i % 2), 64'($urandom_range(0, 255)), 1);
      walk(va, pte, ppn, "R1 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule